// File: doc/BRIEF.md
# Ones and Transition Count Response Compactor

This block compacts the response of a single-output circuit under test into two small signatures. During a test session, each bit marked valid by the response strobe is folded into two counters. One counts the bits that are 1. The other counts the changes in value between consecutive valid bits, in either direction. A register holds the previous valid bit of the session, so the first bit of a session can never add a change.

A session opens with a start pulse. The start pulse empties both counters and forgets the previous bit. The session closes with an end pulse. At that point both counts are compared with golden values that software or a test controller has programmed. The block then raises a one-cycle done flag and a mismatch flag that holds its value.

Both counters saturate at their all-ones value instead of wrapping. The counter width is derived from the longest session the block must support. Generating the stimulus is left to other logic.

Top module: `resp_compactor`

## Requirements
- R1: During and directly after a synchronous reset, `ones_o`, `trans_o`, `done_o` and `err_o` are all 0.
- R2: Each cycle with `vld_i` high and `bit_i` = 1 adds one to `ones_o`, visible in the cycle after the edge that samples it.
- R3: A valid bit that differs from the previous valid bit of the same session adds one to `trans_o`; the first valid bit after start never does.
- R4: A `start_i` pulse clears both counts and `err_o` at the next edge; a valid bit presented in the same cycle as `start_i` is dropped.
- R5: Cycles with `vld_i` low change neither count, and idle gaps between valid bits do not break the change tracking.
- R6: Each count saturates at 2^CNT_W-1 and stays there while further increments arrive.
- R7: An `end_i` pulse raises `done_o` in the next cycle for exactly one cycle, with `err_o` = 1 when `ones_o` differs from `exp_ones_i` or `trans_o` differs from `exp_trans_i`, using the counts as they stood in the `end_i` cycle (a bit valid in that same cycle is counted but not judged).
- R8: `err_o` keeps its value from one end pulse until the next end pulse, start pulse or reset.
- R9: The responses 10000000, 11000000 and 00000000 compact to (ones, changes) = (1,1), (2,1) and (0,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a session, clears counts and previous bit |
| vld_i | input | 1 | Response bit on `bit_i` is valid this cycle |
| bit_i | input | 1 | Response bit from the circuit under test |
| end_i | input | 1 | Closes the session and triggers the comparison |
| exp_ones_i | input | CNT_W | Golden ones count |
| exp_trans_i | input | CNT_W | Golden change count |
| ones_o | output | CNT_W | Current ones count |
| trans_o | output | CNT_W | Current change count |
| done_o | output | 1 | One-cycle pulse after the end of a session |
| err_o | output | 1 | Signature mismatch found at the last end pulse |

## Verification
Each count lands in its output register at the edge that samples the valid bit. The done and mismatch flags follow one edge after the end pulse. The bench drives every input just after a falling edge and reads the outputs at the next falling edge, which is half a period after the edge that updated them. A driver task works out the expected counts and flag for each session, then pushes them into a queue. A monitor pops one entry on each falling edge where done is high, and compares all three values at that moment. Directed checks read the flags a few cycles later, to confirm that done has dropped and that the mismatch flag still holds.

// File: rtl/rc_pkg.sv
package rc_pkg;
  // Bits needed to hold any count from 0 to max_len inclusive.
  function automatic int cnt_width(input int max_len);
    return $clog2(max_len + 1);
  endfunction
endpackage

// File: rtl/rc_sat_counter.sv
module rc_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)
      q <= '0;
    else if (inc && (q != TOP))
      q <= q + 1'b1;
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc && q == TOP) |=> (q == TOP)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(q)); // R5
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0)); // R4
endmodule

// File: rtl/rc_bit_history.sv
module rc_bit_history (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic vld,
  input  logic bit_i,
  output logic one_hit,
  output logic chg_hit
);
  logic prev_q;
  logic have_prev_q;
  logic take;

  assign take    = vld && !clr;
  assign one_hit = take && bit_i;
  assign chg_hit = take && have_prev_q && (prev_q ^ bit_i);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (take) begin
      prev_q      <= bit_i;
      have_prev_q <= 1'b1;
    end
  end

  AST_FIRST_BIT_NO_CHG: assert property (@(posedge clk) disable iff (rst)
    !have_prev_q |-> !chg_hit); // R3
  AST_START_FORGETS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !have_prev_q); // R4
endmodule

// File: rtl/rc_verdict.sv
module rc_verdict #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         fin,
  input  logic [W-1:0] ones,
  input  logic [W-1:0] trans,
  input  logic [W-1:0] exp_ones,
  input  logic [W-1:0] exp_trans,
  output logic         done_o,
  output logic         err_o
);
  logic miss;
  assign miss = (ones != exp_ones) || (trans != exp_trans);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin)
        err_o <= miss;
      else if (clr)
        err_o <= 1'b0;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !fin |=> !done_o); // R7
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!fin && !clr) |=> $stable(err_o)); // R8
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor import rc_pkg::*; #(
  parameter int MAX_LEN = 1024,
  parameter int CNT_W   = cnt_width(MAX_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             vld_i,
  input  logic             bit_i,
  input  logic             end_i,
  input  logic [CNT_W-1:0] exp_ones_i,
  input  logic [CNT_W-1:0] exp_trans_i,
  output logic [CNT_W-1:0] ones_o,
  output logic [CNT_W-1:0] trans_o,
  output logic             done_o,
  output logic             err_o
);
  logic one_hit;
  logic chg_hit;

  rc_bit_history u_hist (
    .clk     (clk),
    .rst     (rst),
    .clr     (start_i),
    .vld     (vld_i),
    .bit_i   (bit_i),
    .one_hit (one_hit),
    .chg_hit (chg_hit)
  );

  rc_sat_counter #(.W(CNT_W)) u_ones (
    .clk (clk),
    .rst (rst),
    .clr (start_i),
    .inc (one_hit),
    .q   (ones_o)
  );

  rc_sat_counter #(.W(CNT_W)) u_trans (
    .clk (clk),
    .rst (rst),
    .clr (start_i),
    .inc (chg_hit),
    .q   (trans_o)
  );

  rc_verdict #(.W(CNT_W)) u_verdict (
    .clk       (clk),
    .rst       (rst),
    .clr       (start_i),
    .fin       (end_i),
    .ones      (ones_o),
    .trans     (trans_o),
    .exp_ones  (exp_ones_i),
    .exp_trans (exp_trans_i),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (ones_o == '0 && trans_o == '0 && !done_o && !err_o)); // R1
  AST_ONES_STEP: assert property (@(posedge clk) disable iff (rst)
    (!start_i && vld_i && !bit_i) |=> $stable(ones_o)); // R2
  AST_CHG_LE_ONES_PAIR: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !vld_i) |=> ($stable(trans_o) && $stable(ones_o))); // R5
endmodule

// File: tb/sim_resp_compactor.sv
`timescale 1ns/1ps
module sim_resp_compactor;
  localparam int MAXL = 12;
  localparam int W    = 4;
  localparam int TOP  = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, vld_i = 0, bit_i = 0, end_i = 0;
  logic [W-1:0] exp_ones_i = '0, exp_trans_i = '0;
  logic [W-1:0] ones_o, trans_o;
  logic done_o, err_o;

  always #4 clk = ~clk;

  resp_compactor #(.MAX_LEN(MAXL)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .vld_i(vld_i), .bit_i(bit_i),
    .end_i(end_i), .exp_ones_i(exp_ones_i), .exp_trans_i(exp_trans_i),
    .ones_o(ones_o), .trans_o(trans_o), .done_o(done_o), .err_o(err_o)
  );

  typedef struct packed {
    logic [W-1:0] o;
    logic [W-1:0] t;
    logic         e;
    logic [3:0]   req;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int sat(input int v);
    return (v > TOP) ? TOP : v;
  endfunction

  // Monitor: on each done pulse, pop and compare.
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) begin
        check(0, "R7 unexpected done", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(ones_o == it.o, $sformatf("R%0d/R2 ones", it.req), ones_o, it.o);
        check(trans_o == it.t, $sformatf("R%0d/R3 trans", it.req), trans_o, it.t);
        check(err_o == it.e, $sformatf("R%0d/R7 err", it.req), err_o, it.e);
      end
    end
  end

  // Driver: one session, bit k of pat is response bit r(k+1).
  task automatic run_session(input logic [31:0] pat, input int len, input int gap,
                             input int off, input logic [3:0] req);
    int o = 0, t = 0;
    item_t it;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    for (int k = 0; k < len; k++) begin
      vld_i = 1; bit_i = pat[k];
      if (pat[k]) o++;
      if (k > 0 && pat[k] != pat[k-1]) t++;
      @(negedge clk);
      vld_i = 0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    o = sat(o); t = sat(t);
    exp_ones_i  = W'(o + off);
    exp_trans_i = W'(t);
    it.o = W'(o); it.t = W'(t); it.e = (off != 0); it.req = req;
    sb.push_back(it);
    end_i = 1;
    @(negedge clk); end_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ones_o == 0, "R1 ones after reset", ones_o, 0);
    check(trans_o == 0, "R1 trans after reset", trans_o, 0);
    check(done_o == 0 && err_o == 0, "R1 flags after reset", {done_o, err_o}, 0);
    rst = 0;
    @(negedge clk);
    check(ones_o == 0 && !done_o, "R1 idle after release", ones_o, 0);

    // R9 reference responses
    run_session(32'h01, 8, 0, 0, 4'd9);
    run_session(32'h03, 8, 0, 0, 4'd9);
    run_session(32'h00, 8, 0, 0, 4'd9);
    // Mixed patterns, R2/R3
    run_session(32'hB5, 8, 0, 0, 4'd3);
    run_session(32'h0F0, 12, 0, 0, 4'd2);
    // R5 gaps between bits
    run_session(32'h69, 8, 3, 0, 4'd5);
    // R6 saturation: 20 ones, then 20 alternating bits
    run_session(32'hFFFFF, 20, 0, 0, 4'd6);
    run_session(32'h55555, 20, 0, 0, 4'd6);

    // R7 mismatch, then R8 hold
    run_session(32'h0D, 6, 0, 1, 4'd7);
    repeat (3) @(negedge clk);
    check(err_o == 1, "R8 err held", err_o, 1);
    check(done_o == 0, "R7 done single cycle", done_o, 0);
    start_i = 1;
    @(negedge clk); start_i = 0;
    check(err_o == 0, "R4 start clears err", err_o, 0);
    check(ones_o == 0 && trans_o == 0, "R4 start clears counts", ones_o + trans_o, 0);

    // R4 bit with start is dropped
    start_i = 1; vld_i = 1; bit_i = 1;
    @(negedge clk); start_i = 0; vld_i = 0;
    check(ones_o == 0, "R4 bit with start dropped", ones_o, 0);
    vld_i = 1; bit_i = 0;
    @(negedge clk); vld_i = 0;
    check(trans_o == 0, "R3 first bit after start no change", trans_o, 0);

    // R7 bit in end cycle counted but not judged: one 1 then 1 with end
    start_i = 1;
    @(negedge clk); start_i = 0;
    vld_i = 1; bit_i = 1;
    @(negedge clk);
    exp_ones_i = 4'd1; exp_trans_i = 4'd0; end_i = 1;
    begin
      item_t it;
      it.o = 4'd2; it.t = 4'd0; it.e = 1'b0; it.req = 4'd7;
      sb.push_back(it);
    end
    @(negedge clk); end_i = 0; vld_i = 0;
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R7 all sessions reported", sb.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule